// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the status flags of an I2C controller. The bus engine sends it single-cycle event pulses: transmit start, end of the slave acknowledge with its ACK/NACK value, bus collision, general-call match, 10-bit address match, Stop seen, device address match, data byte received, and the move of a received byte into the receive buffer. The block folds these pulses into registered flags. It then presents them with five live bus-engine signals as one 32-bit status word.

Software clears the write-collision and receive-overflow flags by writing 0 to their bit positions. The block also watches software writes to the transmit buffer. A write that arrives while the bus is busy is refused and raises the write-collision flag. A write while the bus is idle is passed on as a load strobe. The bus-collision flag ignores software clears and is reset only by turning the module off. While the module is off, every flag reads 0 and every event is ignored.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset, with the live inputs low, the whole status word reads 0. Bits 31..16 and 13..11 always read 0.
- R2: Bit 15 takes the value of `ack_nack` (1 = not acknowledged) on each `ev_ack_done` pulse. It is visible one cycle later and otherwise holds.
- R3: Bit 14 is set by `ev_tx_start` and cleared by `ev_ack_done`, one cycle after the pulse.
- R4: Bit 10 is set by `ev_bus_coll`. A status write of 0 does not clear it. It clears only when `mod_en` goes low, and it stays 0 after the module is enabled again.
- R5: Bit 9 is set by `ev_gcall_hit` and cleared by `ev_stop`.
- R6: Bit 8 is set by `ev_addr10_hit` and cleared by `ev_stop`.
- R7: A `txbuf_wr` while `bus_busy` is high sets bit 7 and keeps `txbuf_load` low in the same cycle. A `txbuf_wr` while idle drives `txbuf_load` high and leaves bit 7 unchanged.
- R8: Bit 6 is set when `ev_rx_xfer` arrives while `lv_rx_full` is high. A transfer into an empty buffer does not set it.
- R9: Bit 5 is cleared by `ev_addr_hit` and set by `ev_data_rx`.
- R10: Bits 4..0 show, from bit 4 down to bit 0, `lv_stop`, `lv_start`, `lv_read`, `lv_rx_full` and `lv_tx_full`, in the same cycle, while the module is enabled.
- R11: A `stat_wr` clears bit 7 when `stat_wdata[7]` is 0 and clears bit 6 when `stat_wdata[6]` is 0. Writing 1 to these bits keeps them, and the write changes no other bit.
- R12: When a set event and a clearing write or clearing event reach the same flag in the same cycle, the flag ends up 1.
- R13: While `mod_en` is low, the status word reads 0, events change no flag, and `txbuf_load` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable |
| ev_tx_start | input | 1 | Master transmission starts |
| ev_ack_done | input | 1 | End of slave acknowledge bit |
| ack_nack | input | 1 | ACK value qualified by ev_ack_done (1 = NACK) |
| ev_bus_coll | input | 1 | Bus collision detected |
| ev_gcall_hit | input | 1 | General call address matched |
| ev_addr10_hit | input | 1 | Second byte of a 10-bit address matched |
| ev_stop | input | 1 | Stop condition detected |
| ev_addr_hit | input | 1 | Device address matched |
| ev_data_rx | input | 1 | Data byte received in slave mode |
| ev_rx_xfer | input | 1 | Shift register moved into the receive buffer |
| lv_stop | input | 1 | Live: Stop seen last |
| lv_start | input | 1 | Live: Start seen last |
| lv_read | input | 1 | Live: direction of the last address (1 = read) |
| lv_rx_full | input | 1 | Live: receive buffer holds an unread byte |
| lv_tx_full | input | 1 | Live: transmit buffer full |
| bus_busy | input | 1 | Engine busy; transmit buffer writes are refused |
| stat_wr | input | 1 | Software write strobe to the status word |
| stat_wdata | input | STAT_W | Software write data |
| txbuf_wr | input | 1 | Software write to the transmit buffer |
| txbuf_load | output | 1 | Accepted transmit buffer write |
| stat_word | output | STAT_W | Status word |

## Verification
The registered flags (bits 15..5) change one clock edge after the pulse or write that causes them. The bench therefore drives its stimulus just after a falling edge, lets one rising edge pass, and samples at the next falling edge. The live bits and `txbuf_load` are combinational. The bench checks them in the same half-cycle in which it drives them, before any edge. Small input spaces are swept in full: all 32 live-bit patterns, both ACK values, and every combination of busy, write, full and transfer.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int STAT_W_MIN = 16;
    localparam int B_ACK   = 15;
    localparam int B_TXB   = 14;
    localparam int B_COLL  = 10;
    localparam int B_GC    = 9;
    localparam int B_A10   = 8;
    localparam int B_WCOL  = 7;
    localparam int B_OVF   = 6;
    localparam int B_DNA   = 5;
    localparam int LIVE_W  = 5;

    typedef struct packed {
        logic ack_nack;
        logic tx_busy;
        logic bus_coll;
        logic gcall;
        logic addr10;
        logic wr_coll;
        logic rx_ovf;
        logic data_not_addr;
    } flags_t;
endpackage

// File: rtl/i2c_stat_txguard.sv
module i2c_stat_txguard (
    input  logic en,
    input  logic txbuf_wr,
    input  logic bus_busy,
    output logic wcol_evt,
    output logic txbuf_load
);
    always_comb begin
        wcol_evt   = en & txbuf_wr & bus_busy;
        txbuf_load = en & txbuf_wr & ~bus_busy;
    end
endmodule

// File: rtl/i2c_stat_core.sv
module i2c_stat_core
    import i2c_stat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   ev_tx_start,
    input  logic   ev_ack_done,
    input  logic   ack_nack,
    input  logic   ev_bus_coll,
    input  logic   ev_gcall_hit,
    input  logic   ev_addr10_hit,
    input  logic   ev_stop,
    input  logic   ev_addr_hit,
    input  logic   ev_data_rx,
    input  logic   ev_rx_xfer,
    input  logic   rx_full,
    input  logic   wcol_evt,
    input  logic   clr_wcol,
    input  logic   clr_ovf,
    output flags_t flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (ev_ack_done) begin
            flags_d.ack_nack = ack_nack;
            flags_d.tx_busy  = 1'b0;
        end
        if (ev_tx_start)               flags_d.tx_busy       = 1'b1;
        if (ev_bus_coll)               flags_d.bus_coll      = 1'b1;
        if (ev_stop) begin
            flags_d.gcall  = 1'b0;
            flags_d.addr10 = 1'b0;
        end
        if (ev_gcall_hit)              flags_d.gcall         = 1'b1;
        if (ev_addr10_hit)             flags_d.addr10        = 1'b1;
        if (clr_wcol)                  flags_d.wr_coll       = 1'b0;
        if (wcol_evt)                  flags_d.wr_coll       = 1'b1;
        if (clr_ovf)                   flags_d.rx_ovf        = 1'b0;
        if (ev_rx_xfer && rx_full)     flags_d.rx_ovf        = 1'b1;
        if (ev_addr_hit)               flags_d.data_not_addr = 1'b0;
        if (ev_data_rx)                flags_d.data_not_addr = 1'b1;
        if (!en)                       flags_d               = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/i2c_stat_pack.sv
module i2c_stat_pack
    import i2c_stat_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              en,
    input  flags_t            flags,
    input  logic [LIVE_W-1:0] live,
    output logic [STAT_W-1:0] word
);
    always_comb begin
        word         = '0;
        word[B_ACK]  = flags.ack_nack;
        word[B_TXB]  = flags.tx_busy;
        word[B_COLL] = flags.bus_coll;
        word[B_GC]   = flags.gcall;
        word[B_A10]  = flags.addr10;
        word[B_WCOL] = flags.wr_coll;
        word[B_OVF]  = flags.rx_ovf;
        word[B_DNA]  = flags.data_not_addr;
        for (int i = 0; i < LIVE_W; i++) begin
            word[i] = en & live[i];
        end
    end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              ev_tx_start,
    input  logic              ev_ack_done,
    input  logic              ack_nack,
    input  logic              ev_bus_coll,
    input  logic              ev_gcall_hit,
    input  logic              ev_addr10_hit,
    input  logic              ev_stop,
    input  logic              ev_addr_hit,
    input  logic              ev_data_rx,
    input  logic              ev_rx_xfer,
    input  logic              lv_stop,
    input  logic              lv_start,
    input  logic              lv_read,
    input  logic              lv_rx_full,
    input  logic              lv_tx_full,
    input  logic              bus_busy,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              txbuf_wr,
    output logic              txbuf_load,
    output logic [STAT_W-1:0] stat_word
);
    flags_t            flags_q;
    logic              wcol_evt;
    logic              clr_wcol;
    logic              clr_ovf;
    logic [LIVE_W-1:0] live;

    always_comb begin
        clr_wcol = stat_wr & ~stat_wdata[B_WCOL];
        clr_ovf  = stat_wr & ~stat_wdata[B_OVF];
        live     = {lv_stop, lv_start, lv_read, lv_rx_full, lv_tx_full};
    end

    i2c_stat_txguard u_guard (
        .en         (mod_en),
        .txbuf_wr   (txbuf_wr),
        .bus_busy   (bus_busy),
        .wcol_evt   (wcol_evt),
        .txbuf_load (txbuf_load)
    );

    i2c_stat_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (mod_en),
        .ev_tx_start   (ev_tx_start),
        .ev_ack_done   (ev_ack_done),
        .ack_nack      (ack_nack),
        .ev_bus_coll   (ev_bus_coll),
        .ev_gcall_hit  (ev_gcall_hit),
        .ev_addr10_hit (ev_addr10_hit),
        .ev_stop       (ev_stop),
        .ev_addr_hit   (ev_addr_hit),
        .ev_data_rx    (ev_data_rx),
        .ev_rx_xfer    (ev_rx_xfer),
        .rx_full       (lv_rx_full),
        .wcol_evt      (wcol_evt),
        .clr_wcol      (clr_wcol),
        .clr_ovf       (clr_ovf),
        .flags_q       (flags_q)
    );

    i2c_stat_pack #(.STAT_W(STAT_W)) u_pack (
        .en    (mod_en),
        .flags (flags_q),
        .live  (live),
        .word  (stat_word)
    );
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_en,
    input logic              ev_tx_start,
    input logic              ev_ack_done,
    input logic              ev_rx_xfer,
    input logic              lv_rx_full,
    input logic              bus_busy,
    input logic              txbuf_wr,
    input logic              txbuf_load,
    input logic [STAT_W-1:0] stat_word
);
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[STAT_W-1:16] == '0) && (stat_word[13:11] == 3'b000));

    a_r3_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && ev_ack_done && !ev_tx_start) |=> !stat_word[14]);

    a_r4_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && stat_word[10]) |=> stat_word[10]);

    a_r7_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && txbuf_wr && bus_busy) |=> stat_word[7]);

    a_r7_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        txbuf_load |-> (!bus_busy && txbuf_wr));

    a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && ev_rx_xfer && lv_rx_full) |=> stat_word[6]);

    a_r13_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (stat_word[15:5] == '0));
endmodule

bind i2c_stat_flags i2c_stat_flags_chk #(.STAT_W(STAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_en      (mod_en),
    .ev_tx_start (ev_tx_start),
    .ev_ack_done (ev_ack_done),
    .ev_rx_xfer  (ev_rx_xfer),
    .lv_rx_full  (lv_rx_full),
    .bus_busy    (bus_busy),
    .txbuf_wr    (txbuf_wr),
    .txbuf_load  (txbuf_load),
    .stat_word   (stat_word)
);

// File: tb/i2c_stat_flags_test.sv
module i2c_stat_flags_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_en = 1'b0;
    logic ev_tx_start = 0, ev_ack_done = 0, ack_nack = 0, ev_bus_coll = 0;
    logic ev_gcall_hit = 0, ev_addr10_hit = 0, ev_stop = 0, ev_addr_hit = 0;
    logic ev_data_rx = 0, ev_rx_xfer = 0;
    logic lv_stop = 0, lv_start = 0, lv_read = 0, lv_rx_full = 0, lv_tx_full = 0;
    logic bus_busy = 0, stat_wr = 0, txbuf_wr = 0;
    logic [W-1:0] stat_wdata = '0;
    logic txbuf_load;
    logic [W-1:0] stat_word;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_stat_flags #(.STAT_W(W)) uut (.*);

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        ev_tx_start = 0; ev_ack_done = 0; ack_nack = 0; ev_bus_coll = 0;
        ev_gcall_hit = 0; ev_addr10_hit = 0; ev_stop = 0; ev_addr_hit = 0;
        ev_data_rx = 0; ev_rx_xfer = 0; stat_wr = 0; stat_wdata = '0;
        txbuf_wr = 0;
    endtask

    // one rising edge, then return at the falling edge with pulses dropped
    task automatic tick();
        @(negedge clk);
        quiet();
    endtask

    task automatic sw_write(logic [W-1:0] v);
        stat_wr = 1; stat_wdata = v;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; mod_en = 1;
        @(negedge clk);
        chk("R1 reset word", stat_word, '0);

        // R10: every live pattern
        for (int v = 0; v < 32; v++) begin
            {lv_stop, lv_start, lv_read, lv_rx_full, lv_tx_full} = v[4:0];
            #1;
            chk("R10 live bits", stat_word, W'(v));
        end
        {lv_stop, lv_start, lv_read, lv_rx_full, lv_tx_full} = '0;

        // R2
        for (int n = 0; n < 2; n++) begin
            ev_ack_done = 1; ack_nack = n[0];
            tick();
            chk("R2 ack status", W'(stat_word[15]), W'(n));
            tick();
            chk("R2 ack holds", W'(stat_word[15]), W'(n));
        end
        ev_ack_done = 1; ack_nack = 0; tick();

        // R3
        ev_tx_start = 1; tick();
        chk("R3 tx set", W'(stat_word[14]), 1);
        ev_ack_done = 1; tick();
        chk("R3 tx clear", W'(stat_word[14]), 0);
        ev_tx_start = 1; ev_ack_done = 1; tick();
        chk("R12 tx set wins", W'(stat_word[14]), 1);
        ev_ack_done = 1; tick();

        // R5 / R6
        ev_gcall_hit = 1; tick();
        chk("R5 gcall set", W'(stat_word[9]), 1);
        ev_addr10_hit = 1; tick();
        chk("R6 addr10 set", W'(stat_word[8]), 1);
        ev_stop = 1; tick();
        chk("R5 R6 stop clears", W'(stat_word[9:8]), 0);

        // R9
        ev_data_rx = 1; tick();
        chk("R9 data set", W'(stat_word[5]), 1);
        ev_addr_hit = 1; tick();
        chk("R9 addr clear", W'(stat_word[5]), 0);

        // R8 sweep
        for (int c = 0; c < 4; c++) begin
            lv_rx_full = c[0]; ev_rx_xfer = c[1];
            tick();
            lv_rx_full = 0;
            #1;
            chk("R8 overflow", W'(stat_word[6]), W'(c[0] & c[1]));
            sw_write('0);
        end

        // R7 sweep
        for (int c = 0; c < 4; c++) begin
            bus_busy = c[0]; txbuf_wr = c[1];
            #1;
            chk("R7 load strobe", W'(txbuf_load), W'(c[1] & ~c[0]));
            tick();
            bus_busy = 0;
            chk("R7 wcol flag", W'(stat_word[7]), W'(c[0] & c[1]));
            sw_write('0);
        end

        // R11 selective clear, R4 sticky
        bus_busy = 1; txbuf_wr = 1; lv_rx_full = 1; ev_rx_xfer = 1; ev_bus_coll = 1;
        tick();
        bus_busy = 0; lv_rx_full = 0;
        chk("R11 setup", stat_word & 32'h04C0, 32'h04C0);
        sw_write(32'hFFFF_FF7F);
        chk("R11 clear wcol only", stat_word & 32'h04C0, 32'h0440);
        sw_write(32'hFFFF_FFBF);
        chk("R11 clear ovf", stat_word & 32'h04C0, 32'h0400);
        sw_write('0);
        chk("R4 write ignored", W'(stat_word[10]), 1);

        // R12 set vs clear
        bus_busy = 1; txbuf_wr = 1; stat_wr = 1; stat_wdata = '0;
        tick();
        bus_busy = 0;
        chk("R12 wcol set wins", W'(stat_word[7]), 1);
        lv_rx_full = 1; ev_rx_xfer = 1; stat_wr = 1; stat_wdata = '0;
        tick();
        lv_rx_full = 0;
        chk("R12 ovf set wins", W'(stat_word[6]), 1);

        // R4 / R13 disable
        mod_en = 0; tick();
        chk("R13 off clears", stat_word, '0);
        ev_tx_start = 1; ev_bus_coll = 1; ev_gcall_hit = 1; ev_data_rx = 1;
        txbuf_wr = 1; bus_busy = 1; lv_stop = 1; lv_rx_full = 1; ev_rx_xfer = 1;
        #1;
        chk("R13 no load when off", W'(txbuf_load), 0);
        tick();
        chk("R13 events ignored", stat_word, '0);
        bus_busy = 0; lv_stop = 0; lv_rx_full = 0;
        mod_en = 1; tick();
        chk("R4 coll cleared after re-enable", stat_word, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule